// File: doc/BRIEF.md
# Test Stimulus and Track-Select Register

This block holds the test-mode logic that sits in front of an encoder's serial readout. A small shift register is loaded from the serial data pin. It shifts on each falling edge of the serial clock, which idles high, and it takes the data pin's level at that edge. The register does one of two jobs, chosen by the mode input, and either job is active only while the test-enable input is high.

In digital test, the serial data pin reaches the downstream output shift path only after it has passed through the test register. Its last stage feeds that path. The block also contains the frame latch. A frame starts on the first falling serial-clock edge that follows a quiet period of at least `IDLE_CYCLES` system clocks. On that edge the frame latch takes the register contents in place of the live track bits, so the test data acts as sensor stimulus. This substitution is suppressed while the unsynchronized binary output mode is selected. In analog test, the register is a mask over the track comparator outputs. The selected outputs are combined by XOR onto a single observation output.

Whenever test is enabled, the configuration input levels are XOR-combined onto the error pin, and that pin is switched to push-pull drive.

Top module: `tst_stim_top`

## Requirements
- R1: After reset the test register, `frameBits` and `frameStrobe` are all zero. The serial clock is treated as having been high, and the quiet-period counter starts at zero.
- R2: While `testEn` is 1, every falling edge of `sclk` (1 in one system clock, 0 in the next) shifts the register left by one place. `serIn` enters bit 0, and bit 4 is the oldest bit.
- R3: With `testEn`=1 and `modeDigital`=1, `chainOut` equals register bit 4. In every other case `chainOut` equals `serIn`.
- R4: One system clock after a falling `sclk` edge that arrives after at least `IDLE_CYCLES` clocks without any `sclk` edge, `frameStrobe` is 1 for one clock and `frameBits` is reloaded. Any other falling edge leaves both unchanged.
- R5: At such a frame start, `frameBits` takes the register value from before that edge's shift if `testEn`=1, `modeDigital`=1 and `noSyncBin`=0. Otherwise it takes `track`.
- R6: While `noSyncBin`=1, a frame start always loads `track`, even in digital test mode.
- R7: With `testEn`=1 and `modeDigital`=0, `sOut` is the XOR of `track[i]` over every bit i that is set in the register, and it is 0 when no bit is set. Outside analog test, `sOut` is 0.
- R8: `errOut` is the XOR of all `cfgPins` bits and `errPushPull` is 1 while `testEn`=1. Both are 0 while `testEn`=0.
- R9: While `testEn`=0, falling `sclk` edges leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| testEn | input | 1 | Enables the test logic |
| modeDigital | input | 1 | 1 selects digital test, 0 selects analog test |
| noSyncBin | input | 1 | Unsynchronized binary output mode selected; blocks stimulus |
| sclk | input | 1 | Serial clock, idles high, active low |
| serIn | input | 1 | Serial data level |
| track | input | 5 | Live track comparator bits, bit 4 is the MSB track |
| cfgPins | input | 7 | Digital configuration input levels |
| frameBits | output | 5 | Bits latched at frame start for the output shift path |
| frameStrobe | output | 1 | One-clock pulse after a frame start |
| chainOut | output | 1 | Serial data toward the output shift path |
| sOut | output | 1 | Analog-test observation of the selected tracks |
| errOut | output | 1 | XOR of the configuration inputs during test |
| errPushPull | output | 1 | Error pin drive is push-pull |

## Verification
A frame start and a register shift can fall on the same serial-clock edge. This happens whenever the first bit of a load arrives after a quiet period. The latch must then take the register value from before the shift, not the value that includes the new bit. The bench causes this on purpose: it loads a known pattern, waits past the quiet period, and clocks another bit. It then checks that `frameBits` equals the old pattern and that `chainOut` already shows the shifted register. The same coincidence occurs many times in a randomized phase, where a behavioural model is compared with the design on every clock.

// File: rtl/tst_pkg.sv
`timescale 1ns/1ps
package tst_pkg;
  typedef struct packed {
    logic shiftEn;
    logic frameStart;
    logic useStim;
  } tstStrobes_t;
endpackage

// File: rtl/tst_ctrl.sv
`timescale 1ns/1ps
module tst_ctrl #(
  parameter int IDLE_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                testEn,
  input  logic                modeDigital,
  input  logic                noSyncBin,
  input  logic                sclk,
  output tst_pkg::tstStrobes_t strobes,
  output logic                digTest,
  output logic                anaTest
);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_CYCLES);

  logic              sclkD;
  logic [IDLE_W-1:0] idleCnt;
  logic              fallEdge;
  logic              anyEdge;
  logic              idleDone;

  assign fallEdge = sclkD & ~sclk;
  assign anyEdge  = sclkD ^ sclk;
  assign idleDone = (idleCnt == IDLE_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkD   <= 1'b1;
      idleCnt <= '0;
    end else begin
      sclkD <= sclk;
      if (anyEdge)
        idleCnt <= '0;
      else if (!idleDone)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  assign digTest = testEn & modeDigital;
  assign anaTest = testEn & ~modeDigital;

  always_comb begin
    strobes            = '0;
    strobes.shiftEn    = fallEdge & testEn;
    strobes.frameStart = fallEdge & idleDone;
    strobes.useStim    = digTest & ~noSyncBin;
  end

  AST_IDLE_SAT: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= IDLE_MAX); // R4
  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    anyEdge |=> (idleCnt == '0)); // R4
  AST_NO_STIM_NOSYNC: assert property (@(posedge clk) disable iff (!rstN)
    noSyncBin |-> !strobes.useStim); // R6
endmodule

// File: rtl/tst_datapath.sv
`timescale 1ns/1ps
module tst_datapath #(
  parameter int NUM_TRACKS = 5,
  parameter int NUM_CFG    = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tst_pkg::tstStrobes_t  strobes,
  input  logic                  digTest,
  input  logic                  anaTest,
  input  logic                  testEn,
  input  logic                  serIn,
  input  logic [NUM_TRACKS-1:0] track,
  input  logic [NUM_CFG-1:0]    cfgPins,
  output logic [NUM_TRACKS-1:0] frameBits,
  output logic                  frameStrobe,
  output logic                  chainOut,
  output logic                  sOut,
  output logic                  errOut,
  output logic                  errPushPull
);
  localparam int MSB = NUM_TRACKS - 1;

  logic [NUM_TRACKS-1:0] testReg;
  logic [NUM_TRACKS-1:0] selBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testReg <= '0;
    end else if (strobes.shiftEn) begin
      testReg <= {testReg[MSB-1:0], serIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBits   <= '0;
      frameStrobe <= 1'b0;
    end else begin
      frameStrobe <= strobes.frameStart;
      if (strobes.frameStart)
        frameBits <= strobes.useStim ? testReg : track;
    end
  end

  for (genvar i = 0; i < NUM_TRACKS; i++) begin : gSel
    assign selBits[i] = testReg[i] & track[i];
  end

  assign sOut        = anaTest & (^selBits);
  assign chainOut    = digTest ? testReg[MSB] : serIn;
  assign errOut      = testEn & (^cfgPins);
  assign errPushPull = testEn;

  AST_CAPTURE_STIM: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && $past(strobes.useStim)) |-> (frameBits == $past(testReg))); // R5
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |-> $stable(frameBits)); // R4
  AST_REG_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> $stable(testReg)); // R9
  AST_SOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !anaTest |-> !sOut); // R7
endmodule

// File: rtl/tst_stim_top.sv
`timescale 1ns/1ps
module tst_stim_top #(
  parameter int NUM_TRACKS  = 5,
  parameter int NUM_CFG     = 7,
  parameter int IDLE_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  testEn,
  input  logic                  modeDigital,
  input  logic                  noSyncBin,
  input  logic                  sclk,
  input  logic                  serIn,
  input  logic [NUM_TRACKS-1:0] track,
  input  logic [NUM_CFG-1:0]    cfgPins,
  output logic [NUM_TRACKS-1:0] frameBits,
  output logic                  frameStrobe,
  output logic                  chainOut,
  output logic                  sOut,
  output logic                  errOut,
  output logic                  errPushPull
);
  tst_pkg::tstStrobes_t strobes;
  logic digTest;
  logic anaTest;

  tst_ctrl #(.IDLE_CYCLES(IDLE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .testEn(testEn), .modeDigital(modeDigital),
    .noSyncBin(noSyncBin), .sclk(sclk), .strobes(strobes),
    .digTest(digTest), .anaTest(anaTest)
  );

  tst_datapath #(.NUM_TRACKS(NUM_TRACKS), .NUM_CFG(NUM_CFG)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .digTest(digTest),
    .anaTest(anaTest), .testEn(testEn), .serIn(serIn), .track(track),
    .cfgPins(cfgPins), .frameBits(frameBits), .frameStrobe(frameStrobe),
    .chainOut(chainOut), .sOut(sOut), .errOut(errOut),
    .errPushPull(errPushPull)
  );

  AST_NOSYNC_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (frameStrobe && $past(noSyncBin)) |-> (frameBits == $past(track))); // R6
endmodule

// File: tb/tst_stim_top_test.sv
`timescale 1ns/1ps
module tst_stim_top_test;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testEn = 1'b0, modeDigital = 1'b1, noSyncBin = 1'b0;
  logic sclk = 1'b1, serIn = 1'b0;
  logic [4:0] track = '0;
  logic [6:0] cfgPins = '0;
  logic [4:0] frameBits;
  logic frameStrobe, chainOut, sOut, errOut, errPushPull;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tst_stim_top #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rstN(rstN), .testEn(testEn), .modeDigital(modeDigital),
    .noSyncBin(noSyncBin), .sclk(sclk), .serIn(serIn), .track(track),
    .cfgPins(cfgPins), .frameBits(frameBits), .frameStrobe(frameStrobe),
    .chainOut(chainOut), .sOut(sOut), .errOut(errOut),
    .errPushPull(errPushPull)
  );

  // behavioural reference
  int mReg = 0, mFrame = 0, mIdle = 0;
  bit mStrobe = 0, mPrev = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 0; mFrame = 0; mIdle = 0; mStrobe = 0; mPrev = 1;
    end else begin
      bit fall;
      bit edgeSeen;
      fall = mPrev && !sclk;
      edgeSeen = (mPrev != sclk);
      mStrobe = fall && (mIdle >= IDLE);
      if (mStrobe)
        mFrame = (testEn && modeDigital && !noSyncBin) ? mReg : int'(track);
      if (fall && testEn)
        mReg = ((mReg * 2) + int'(serIn)) % 32;
      if (edgeSeen) mIdle = 0;
      else if (mIdle < IDLE) mIdle = mIdle + 1;
      mPrev = sclk;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int xorMasked(int m, int t);
    int r = 0;
    for (int i = 0; i < 5; i++) r ^= ((m >> i) & (t >> i) & 1);
    return r;
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R5 frameBits", int'(frameBits), mFrame);
      chk("R4 frameStrobe", int'(frameStrobe), int'(mStrobe));
      chk("R3 chainOut", int'(chainOut),
          (testEn && modeDigital) ? ((mReg >> 4) & 1) : int'(serIn));
      chk("R7 sOut", int'(sOut),
          (testEn && !modeDigital) ? xorMasked(mReg, int'(track)) : 0);
      chk("R8 errOut", int'(errOut), testEn ? int'(^cfgPins) : 0);
      chk("R8 errPushPull", int'(errPushPull), int'(testEn));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shiftBit(bit b);
    serIn = b; sclk = 1'b0; cyc(2);
    sclk = 1'b1; cyc(2);
  endtask

  task automatic loadReg(logic [4:0] v);
    for (int i = 4; i >= 0; i--) shiftBit(v[i]);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    cyc(4);
    rstN = 1'b1; testEn = 1'b1; modeDigital = 1'b1;
    @(negedge clk);
    chk("R1 frameBits reset", int'(frameBits), 0);
    chk("R1 frameStrobe reset", int'(frameStrobe), 0);
    chk("R1 register zero via chainOut", int'(chainOut), 0);
    cyc(1);

    // R2: shift pattern and observe oldest bit
    loadReg(5'b10110);
    chk("R2 bit4 after load", int'(chainOut), 1);
    serIn = 1'b0;
    chk("R3 digital chain ignores serIn", int'(chainOut), 1);

    // R4: short idle does not start a frame
    cyc(8);
    sclk = 1'b0; @(posedge clk); @(negedge clk);
    chk("R4 no frame after short idle", int'(frameStrobe), 0);
    cyc(1); sclk = 1'b1; cyc(2);
    // register is now 01100; long idle then frame start coinciding with shift
    cyc(IDLE + 4);
    serIn = 1'b1; sclk = 1'b0; @(posedge clk); @(negedge clk);
    chk("R4 strobe after long idle", int'(frameStrobe), 1);
    chk("R5 pre-shift stimulus captured", int'(frameBits), 5'b01100);
    chk("R2 shifted on same edge", int'(chainOut), 1);
    cyc(1); sclk = 1'b1; cyc(2);

    // R6: no stimulus in unsynchronized binary mode
    noSyncBin = 1'b1; track = 5'b01001;
    cyc(IDLE + 4);
    sclk = 1'b0; @(posedge clk); @(negedge clk);
    chk("R6 live track captured", int'(frameBits), 5'b01001);
    cyc(1); sclk = 1'b1; noSyncBin = 1'b0; cyc(2);

    // R7: analog track select
    modeDigital = 1'b0;
    loadReg(5'b10100);
    track = 5'b10000; cyc(1);
    chk("R7 single track", int'(sOut), 1);
    track = 5'b10100; cyc(1);
    chk("R7 two tracks XOR", int'(sOut), 0);
    track = 5'b01011; cyc(1);
    chk("R7 unselected tracks", int'(sOut), 0);
    loadReg(5'b00000);
    track = 5'b11111; cyc(1);
    chk("R7 empty mask", int'(sOut), 0);
    loadReg(5'b11100);

    // R9: shifts ignored while disabled
    testEn = 1'b0; cyc(1);
    chk("R3 chain passes serIn when off", int'(chainOut), int'(serIn));
    for (int i = 0; i < 5; i++) shiftBit(1'b0);
    testEn = 1'b1; modeDigital = 1'b0; track = 5'b11111; cyc(1);
    chk("R9 mask kept while disabled", int'(sOut), 1);
    modeDigital = 1'b1; cyc(1);
    chk("R9 bit4 kept while disabled", int'(chainOut), 1);

    // R8: configuration XOR
    cfgPins = 7'b0000001; cyc(1);
    chk("R8 one cfg high", int'(errOut), 1);
    cfgPins = 7'b1100011; cyc(1);
    chk("R8 four cfg high", int'(errOut), 0);
    testEn = 1'b0; cyc(1);
    chk("R8 off when disabled", int'(errOut), 0);
    chk("R8 push-pull off when disabled", int'(errPushPull), 0);

    // randomized phase compared against the model every clock
    for (int n = 0; n < 300; n++) begin
      int gap;
      gap = ($urandom % 5 == 0) ? (IDLE + 1 + $urandom % 6) : (1 + $urandom % 3);
      for (int g = 0; g < gap; g++) begin
        serIn = 1'($urandom); track = 5'($urandom); cfgPins = 7'($urandom);
        if ($urandom % 16 == 0) testEn = 1'($urandom);
        if ($urandom % 16 == 0) modeDigital = 1'($urandom);
        if ($urandom % 16 == 0) noSyncBin = 1'($urandom);
        cyc(1);
      end
      sclk = ~sclk;
    end
    cyc(4);
    finishRun();
  end
endmodule